// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the levels of a small GPIO port into one interrupt request. Every pin has its own configuration. It can detect edges or levels. In edge mode it can detect both edges or one chosen edge, and a polarity bit picks that edge. In level mode the same polarity bit picks the active level. Detected events latch into a raw status register. A mask register selects which raw bits drive the single interrupt line.

Software programs the configuration through a word-indexed write port. It reads raw and masked status through a combinational read port and acknowledges events by writing ones to a clear address. The pin levels are assumed to be synchronized already. The direction vector comes from the port's data path. A pin driven as an output never produces an edge event.

The detector keeps one flop per pin that holds the previous pin level, and that flop resets to 0. A pin that is already high when reset is released therefore counts as a rising change on the first active cycle. There are no states to sequence: each cycle the event vector is computed combinationally and merged into the raw status flops.

Top module: `gid_irq_top`

## Requirements
- R1: After reset the sense, both-edges, polarity, mask and raw status registers read 0 and `irq` is low.
- R2: Writes to address 0 (sense), 1 (both-edges), 2 (polarity) and 3 (mask) store the low `NPINS` bits of `wr_data`. Reading the same address returns them.
- R3: With a pin's sense bit at 0 (edge) and its both-edges bit at 1, any change of that input pin between two clock edges sets its raw status bit at the second edge.
- R4: With sense 0 and both-edges 0, a change sets the raw bit only when the new level equals the polarity bit (1 = rising, 0 = falling).
- R5: With sense 1 (level), the raw bit is set on every edge at which the pin level equals the polarity bit, so it is set again right after a clear while that level lasts.
- R6: Writing to address 6 clears the raw bits whose `wr_data` bits are 1. Bits written as 0 are left unchanged.
- R7: Address 5 reads raw status AND mask, and `irq` is high exactly when that value is nonzero.
- R8: A pin whose `pin_dir` bit is 1 (output) produces no edge event.
- R9: When a clear and a new event hit the same bit in one cycle, the bit stays set.
- R10: Address 4 reads raw status. Writes to addresses 4 and 5 change nothing. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Synchronized pin levels |
| pin_dir | input | NPINS | Direction per pin, 1 = output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word index |
| wr_data | input | NPINS | Write data |
| rd_addr | input | 3 | Read word index |
| rd_data | output | NPINS | Read data, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A software clear and a fresh pin event can land on the same raw bit in one cycle. A level source can also re-assert a bit in the very cycle that clears it. The bench provokes the first case by changing a pin on the same falling edge that presents the clear write. It provokes the second case by clearing while a level-mode pin sits at its active level. In both cases the raw status read one cycle later must still show the bit set. A sweep over every sense, both-edges and polarity combination, with several pin transitions each, computes the expected raw value arithmetically from the old level, the new level and the mode.

// File: rtl/gid_pkg.sv
package gid_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SENSE  = 3'd0,
        SEL_BOTH   = 3'd1,
        SEL_POL    = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_RAW    = 3'd4,
        SEL_MASKED = 3'd5,
        SEL_CLEAR  = 3'd6,
        SEL_SPARE  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gid_cfg_regs.sv
module gid_cfg_regs
    import gid_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_SENSE: sense_q <= wr_data;
                SEL_BOTH:  both_q  <= wr_data;
                SEL_POL:   pol_q   <= wr_data;
                SEL_MASK:  mask_q  <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gid_event_detect.sv
module gid_event_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_dir,
    input  logic [NPINS-1:0] sense_q,
    input  logic [NPINS-1:0] both_q,
    input  logic [NPINS-1:0] pol_q,
    output logic [NPINS-1:0] evt
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic changed;
        logic at_pol;
        logic edge_hit;
        always_comb begin
            changed  = (pin_in[g] ^ prev_q[g]) & ~pin_dir[g];
            at_pol   = (pin_in[g] == pol_q[g]);
            edge_hit = changed & (both_q[g] | at_pol);
            evt[g]   = sense_q[g] ? at_pol : edge_hit;
        end
    end
endmodule

// File: rtl/gid_status.sv
module gid_status #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic             clr_en,
    input  logic [NPINS-1:0] clr_bits,
    output logic [NPINS-1:0] raw_q
);
    logic [NPINS-1:0] clr_vec;

    always_comb clr_vec = clr_en ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | evt;
    end
endmodule

// File: rtl/gid_irq_top.sv
module gid_irq_top
    import gid_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_dir,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NPINS-1:0]  rd_data,
    output logic              irq
);
    logic [NPINS-1:0] sense_q;
    logic [NPINS-1:0] both_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] raw_q;
    logic [NPINS-1:0] masked;
    logic             clr_en;

    gid_cfg_regs #(.NPINS(NPINS)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .mask_q(mask_q)
    );

    gid_event_detect #(.NPINS(NPINS)) det_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q), .evt(evt)
    );

    always_comb clr_en = wr_en && (reg_sel_e'(wr_addr) == SEL_CLEAR);

    gid_status #(.NPINS(NPINS)) sts_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr_en(clr_en),
        .clr_bits(wr_data), .raw_q(raw_q)
    );

    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_SENSE:  rd_data = sense_q;
            SEL_BOTH:   rd_data = both_q;
            SEL_POL:    rd_data = pol_q;
            SEL_MASK:   rd_data = mask_q;
            SEL_RAW:    rd_data = raw_q;
            SEL_MASKED: rd_data = masked;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gid_irq_checker.sv
module gid_irq_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_dir,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] sense_q,
    input logic [NPINS-1:0] pol_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] evt,
    input logic [NPINS-1:0] raw_q,
    input logic             irq
);
    logic             clr_w;
    logic [NPINS-1:0] lvl_active;

    always_comb begin
        clr_w      = wr_en && (wr_addr == 3'd6);
        lvl_active = sense_q & ~(pin_in ^ pol_q);
    end

    // New raw bits need a detected event in the previous cycle (R3, R4)
    assert_set_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt)) == '0));

    // Output pins in edge mode never raise a raw bit
    assert_outpin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & $past(pin_dir & ~sense_q)) == '0));

    // Level sources hold their bit set
    assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(lvl_active)) == $past(lvl_active)));

    // Cleared bits without a same-cycle event drop
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> ((raw_q & $past(wr_data) & ~$past(evt)) == '0));

    // Event beats a clear on the same bit
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> ((raw_q & $past(evt)) == $past(evt)));

    // Interrupt needs a mask bit
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));
endmodule

bind gid_irq_top gid_irq_checker #(.NPINS(NPINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sense_q(sense_q), .pol_q(pol_q), .mask_q(mask_q),
    .evt(evt), .raw_q(raw_q), .irq(irq)
);

// File: tb/gid_irq_top_tb_top.sv
module gid_irq_top_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_dir = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gid_irq_top #(.NPINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [N-1:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] olds [4] = '{8'h00, 8'hFF, 8'hA5, 8'h0F};
        logic [N-1:0] news [4] = '{8'hFF, 8'h00, 8'h5A, 8'h3C};
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, '0);
        end
        check("R1 irq low", {7'b0, irq}, '0);

        // R2: config write/readback
        for (int a = 0; a < 4; a++) begin
            wr(3'(a), 8'h3C ^ 8'(a * 17));
            rd(3'(a), v);
            check("R2 readback", v, 8'h3C ^ 8'(a * 17));
        end
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd6, 8'hFF);

        // R3 R4 R5 R7: sweep over mode and transition
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 4; p++) begin
                logic [N-1:0] sv, bv, ev, o, nw, lvl_o, lvl_n, edg, exp;
                sv = {N{m[2]}}; bv = {N{m[1]}}; ev = {N{m[0]}};
                o = olds[p]; nw = news[p];
                wr(3'd0, sv); wr(3'd1, bv); wr(3'd2, ev);
                wr(3'd3, (p % 2 == 0) ? 8'hFF : 8'h00);
                pin_in = o;
                step(2);
                wr(3'd6, 8'hFF);
                lvl_o = sv & ~(o ^ ev);
                lvl_n = sv & ~(nw ^ ev);
                edg   = ~sv & (o ^ nw) & (bv | ~(nw ^ ev));
                pin_in = nw;
                step(1);
                exp = lvl_o | lvl_n | edg;
                rd(3'd4, v);
                check(m[2] ? "R5 level raw" : (m[1] ? "R3 both raw" : "R4 edge raw"), v, exp);
                rd(3'd5, v);
                check("R7 masked", v, (p % 2 == 0) ? exp : 8'h00);
                check("R7 irq", {7'b0, irq}, {7'b0, (p % 2 == 0) && (exp != 0)});
            end
        end

        // R5: level re-asserts right after clear
        wr(3'd0, 8'hFF); wr(3'd2, 8'h00); pin_in = 8'h0F; step(1);
        wr(3'd6, 8'hFF);
        rd(3'd4, v);
        check("R5 level reassert", v, 8'hF0);

        // R8: output pins ignored
        wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd3, 8'h00);
        pin_dir = 8'hF0; pin_in = 8'h00; step(2);
        wr(3'd6, 8'hFF);
        pin_in = 8'hFF; step(1);
        rd(3'd4, v);
        check("R8 output pins", v, 8'h0F);
        pin_dir = 8'h00;

        // R6: partial clear
        pin_in = 8'h00; step(1);
        rd(3'd4, v);
        check("R6 setup all set", v, 8'hFF);
        wr(3'd6, 8'h0F);
        rd(3'd4, v);
        check("R6 partial clear", v, 8'hF0);

        // R9: clear and edge in the same cycle
        wr(3'd6, 8'hFF);
        pin_in = 8'h01;
        wr(3'd6, 8'h03);
        rd(3'd4, v);
        check("R9 event wins", v, 8'h01);

        // R10: read-only and spare addresses
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        rd(3'd4, v);
        check("R10 raw unchanged", v, 8'h01);
        rd(3'd6, v);
        check("R10 clear reads 0", v, 8'h00);
        rd(3'd7, v);
        check("R10 spare reads 0", v, 8'h00);
        rd(3'd3, v);
        check("R10 mask unchanged", v, 8'h00);

        // R7: mask selects irq
        wr(3'd3, 8'h02);
        check("R7 irq off", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h01);
        check("R7 irq on", {7'b0, irq}, 8'h01);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule